// File: doc/BRIEF.md
# Serial Frame Checksum Unit (x^4 + x + 1)

This block computes and verifies a 4-bit polynomial checksum over a 15-bit serial frame. The frame carries 11 message bits followed by 4 check positions. Bits arrive one per qualified cycle, with the first bit of the frame arriving first. They pass through a 4-stage shift register whose feedback follows the primitive polynomial x^4 + x + 1.

In generate mode the block treats the 4 check positions as zeros, whatever the serial input carries in those cycles. The register content left at the end of the frame is the checksum, and the sender puts it into those positions. In check mode all 15 received bits feed the register. A frame that carries its proper checksum drives the register back to zero. A nonzero final value raises an error flag, which stays up until the next frame begins.

A one-cycle pulse marks the end of each frame. A new frame is announced by a start pulse. That pulse clears the register and the bit count, and it captures the mode for the whole frame.

Top module: `lfsr_fcs`

## Requirements
- R1: After reset (synchronous, active-low `rstN`), `remainder` is 0000, and `frameDone` and `frameError` are 0.
- R2: A cycle with `frameStart` high clears the register, the bit count and `frameError`. No serial bit is taken in that cycle, even when `bitValid` is high.
- R3: Each accepted bit updates the register, where bit 0 is stage 1 and bit 3 is stage 4: new bit0 = bit3 XOR input bit, new bit1 = bit0 XOR bit3, new bit2 = bit1, new bit3 = bit2.
- R4: A cycle with `bitValid` low leaves the register, the bit count and the flags unchanged.
- R5: The mode is sampled from `checkMode` in the `frameStart` cycle (1 = check, 0 = generate) and holds for the whole frame. Changes of `checkMode` during the frame have no effect.
- R6: In generate mode, the serial input is ignored for accepted bits 12 to 15 and a 0 is used instead. The 11-bit message 11001000111 leaves `remainder` = 1010.
- R7: `frameDone` is high for exactly one cycle: the cycle after the clock edge that takes the 15th accepted bit. In that cycle `remainder` shows the final register value.
- R8: Once 15 bits have been taken, further valid bits are ignored until the next `frameStart`.
- R9: In check mode, `frameError` rises together with `frameDone` when the final register value is nonzero. The frame 110010001111010 ends at 0000 and raises no error.
- R10: `frameError` holds until the next `frameStart` and is never set by a generate-mode frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| bitValid | input | 1 | Qualifies `bitIn` in this cycle |
| bitIn | input | 1 | Serial data, first frame bit first |
| frameStart | input | 1 | Starts a new frame and samples the mode |
| checkMode | input | 1 | 1 = check received frame, 0 = generate checksum |
| remainder | output | 4 | Current register content; the checksum at frame end |
| frameDone | output | 1 | One-cycle pulse after the 15th accepted bit |
| frameError | output | 1 | Check mode: nonzero final remainder, held until the next frame |

## Verification
The bench builds the block with its default parameters: a 4-bit register, the x^4 + x + 1 taps, and an 11-bit message inside a 15-cycle frame. This keeps the whole nonzero state cycle of the register short enough that every frame runs to completion many times. Each checksum produced in generate mode is fed back in check mode, so the zero-return property is exercised on many messages. Frames with a single corrupted bit confirm that the error flag is set. Idle gaps, surplus bits, restarts in the middle of a frame and mode changes during a frame exercise the hold and ignore rules.

// File: rtl/lfsr_fcs_pkg.sv
package lfsr_fcs_pkg;
  // strobes from the frame sequencer to the shift datapath
  typedef struct packed {
    logic clear;   // start of frame: wipe register and error
    logic shift;   // take one serial bit this cycle
    logic zeroIn;  // substitute a zero for the serial bit
    logic last;    // this shift is the final one of the frame
  } fcsStrobe_t;
endpackage

// File: rtl/lfsr_fcs_ctrl.sv
module lfsr_fcs_ctrl
  import lfsr_fcs_pkg::*;
#(
  parameter int FRAME_BITS = 15,
  parameter int MSG_BITS   = 11
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitValid,
  input  logic       frameStart,
  input  logic       checkMode,
  output fcsStrobe_t strb,
  output logic       checkActive,
  output logic       frameDone
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] FRAME_CNT = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] MSG_CNT   = CNT_W'(MSG_BITS);

  logic [CNT_W-1:0] bitCnt;
  logic             modeQ;
  logic             doneQ;

  always_comb begin
    strb.clear  = frameStart;
    strb.shift  = !frameStart && bitValid && (bitCnt < FRAME_CNT);
    strb.zeroIn = !modeQ && (bitCnt >= MSG_CNT);
    strb.last   = strb.shift && (bitCnt == LAST_CNT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
      modeQ  <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= strb.last;
      if (frameStart) begin
        bitCnt <= '0;
        modeQ  <= checkMode;
      end else if (strb.shift) begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  assign checkActive = modeQ;
  assign frameDone   = doneQ;
endmodule

// File: rtl/lfsr_fcs_dp.sv
module lfsr_fcs_dp
  import lfsr_fcs_pkg::*;
#(
  parameter int               WIDTH = 4,
  parameter logic [WIDTH-1:0] TAPS  = 4'b0011
) (
  input  logic             clk,
  input  logic             rstN,
  input  fcsStrobe_t       strb,
  input  logic             bitIn,
  input  logic             checkActive,
  output logic [WIDTH-1:0] remainder,
  output logic             frameError
);
  logic [WIDTH-1:0] regQ;
  logic [WIDTH-1:0] regNext;
  logic             dataBit;
  logic             topBit;
  logic             errQ;

  assign dataBit = bitIn & ~strb.zeroIn;
  assign topBit  = regQ[WIDTH-1];

  // one stage per register bit; a tap adds the top bit into that stage
  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign regNext[i] = dataBit ^ (TAPS[i] & topBit);
    end else begin : g_rest
      assign regNext[i] = regQ[i-1] ^ (TAPS[i] & topBit);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regQ <= '0;
      errQ <= 1'b0;
    end else if (strb.clear) begin
      regQ <= '0;
      errQ <= 1'b0;
    end else if (strb.shift) begin
      regQ <= regNext;
      if (strb.last && checkActive) errQ <= |regNext;
    end
  end

  assign remainder  = regQ;
  assign frameError = errQ;
endmodule

// File: rtl/lfsr_fcs.sv
module lfsr_fcs
  import lfsr_fcs_pkg::*;
#(
  parameter int               WIDTH    = 4,
  parameter logic [WIDTH-1:0] TAPS     = 4'b0011,
  parameter int               MSG_BITS = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitValid,
  input  logic             bitIn,
  input  logic             frameStart,
  input  logic             checkMode,
  output logic [WIDTH-1:0] remainder,
  output logic             frameDone,
  output logic             frameError
);
  localparam int FRAME_BITS = (1 << WIDTH) - 1;

  fcsStrobe_t strb;
  logic       checkActive;

  lfsr_fcs_ctrl #(.FRAME_BITS(FRAME_BITS), .MSG_BITS(MSG_BITS)) ctrl_i (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .frameStart(frameStart),
    .checkMode(checkMode), .strb(strb), .checkActive(checkActive),
    .frameDone(frameDone)
  );

  lfsr_fcs_dp #(.WIDTH(WIDTH), .TAPS(TAPS)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .bitIn(bitIn),
    .checkActive(checkActive), .remainder(remainder), .frameError(frameError)
  );
endmodule

// File: rtl/lfsr_fcs_chk.sv
module lfsr_fcs_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             bitValid,
  input logic             frameStart,
  input logic [WIDTH-1:0] remainder,
  input logic             frameDone,
  input logic             frameError
);
  AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> (remainder == '0) && !frameError && !frameDone); // R2

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!frameStart && !bitValid) |=> $stable(remainder)); // R4

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone); // R7

  AST_ERROR_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameError) |-> frameDone && (remainder != '0)); // R9

  AST_ERROR_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (frameError && !frameStart) |=> frameError); // R10
endmodule

bind lfsr_fcs lfsr_fcs_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rstN(rstN), .bitValid(bitValid), .frameStart(frameStart),
  .remainder(remainder), .frameDone(frameDone), .frameError(frameError)
);

// File: tb/lfsr_fcs_tb_top.sv
`timescale 1ns/1ps
module lfsr_fcs_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rstN = 1'b0, bitValid = 1'b0, bitIn = 1'b0;
  logic       frameStart = 1'b0, checkMode = 1'b0;
  logic [3:0] remainder;
  logic       frameDone, frameError;

  lfsr_fcs dut_i (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitIn(bitIn),
    .frameStart(frameStart), .checkMode(checkMode), .remainder(remainder),
    .frameDone(frameDone), .frameError(frameError)
  );

  int    vectors = 0, fails = 0, cycles = 0;
  string curReq = "R1";
  bit    running = 0;

  // behavioural reference: polynomial division with integers
  int mSt = 0, mCnt = 0;
  bit mMode = 0, mDone = 0, mErr = 0;
  always @(posedge clk) begin
    int b, n;
    if (!rstN) begin
      mSt = 0; mCnt = 0; mMode = 0; mDone = 0; mErr = 0;
    end else if (frameStart) begin
      mSt = 0; mCnt = 0; mMode = checkMode; mDone = 0; mErr = 0;
    end else begin
      mDone = 0;
      if (bitValid && mCnt < 15) begin
        b = (!mMode && mCnt >= 11) ? 0 : int'(bitIn);
        n = (mSt * 2) + b;
        if (n >= 16) n = n ^ 19;   // subtract x^4+x+1
        mSt = n;
        if (mCnt == 14) begin
          mDone = 1;
          if (mMode && n != 0) mErr = 1;
        end
        mCnt = mCnt + 1;
      end
    end
  end

  always @(negedge clk) if (running) begin
    vectors++;
    if (remainder !== 4'(mSt) || frameDone !== mDone || frameError !== mErr) begin
      fails++;
      $display("FAIL %s cycle: rem/done/err actual %b/%b/%b expected %b/%b/%b",
               curReq, remainder, frameDone, frameError, 4'(mSt), mDone, mErr);
    end
  end

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic start(bit m);
    frameStart = 1; checkMode = m; bitValid = $urandom_range(0, 1); bitIn = 1;
    @(negedge clk);
    frameStart = 0; bitValid = 0;
  endtask

  task automatic sendBits(logic [14:0] f, int n, bit gaps);
    for (int i = 14; i > 14 - n; i--) begin
      bitValid = 1; bitIn = f[i];
      @(negedge clk);
      if (gaps) begin
        bitValid = 0; bitIn = 1'($urandom);
        repeat ($urandom_range(0, 2)) @(negedge clk);
      end
    end
    bitValid = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : stim
    logic [10:0] msg;
    logic [3:0]  rem;
    repeat (3) @(negedge clk);
    running = 1;
    chk("R1", {remainder[3:1], remainder[0] | frameDone | frameError}, 4'b0000);
    rstN = 1;
    @(negedge clk);

    // R3: first steps of the known frame
    curReq = "R3";
    start(0);
    sendBits(15'b110000000000000, 3, 0);
    chk("R3", remainder, 4'b0110);

    // R2: restart mid-frame, then the known message with ones in check slots
    curReq = "R2";
    start(0);
    chk("R2", remainder, 4'b0000);
    curReq = "R6";
    sendBits(15'b110010001111111, 15, 0);
    chk("R6", remainder, 4'b1010);
    chk("R7", {3'b0, frameDone}, 4'b0001);
    chk("R10", {3'b0, frameError}, 4'b0000);
    @(negedge clk);
    chk("R7", {3'b0, frameDone}, 4'b0000);

    // R8: surplus bits after frame end
    curReq = "R8";
    sendBits(15'b101101101101101, 6, 0);
    chk("R8", remainder, 4'b1010);

    // R9: proper frame checks clean, R4 gaps inserted
    curReq = "R9";
    start(1);
    sendBits(15'b110010001111010, 15, 1);
    chk("R9", remainder, 4'b0000);
    chk("R9", {3'b0, frameError}, 4'b0000);

    // R9/R10: corrupted frame, flag holds, cleared by start
    start(1);
    sendBits(15'b110011001111010, 15, 0);
    chk("R9", {3'b0, frameError}, 4'b0001);
    curReq = "R10";
    repeat (5) @(negedge clk);
    chk("R10", {3'b0, frameError}, 4'b0001);
    start(0);
    chk("R2", {3'b0, frameError}, 4'b0000);

    // R5: mode flips during a check frame have no effect
    curReq = "R5";
    start(1);
    checkMode = 0;
    sendBits(15'b110010001110001, 15, 0);
    chk("R5", {3'b0, frameError}, 4'b0001);

    // R4: gapped random frames, both modes, round trip generate -> check
    curReq = "R4";
    for (int k = 0; k < 30; k++) begin
      msg = 11'($urandom);
      start(0);
      sendBits({msg, 4'($urandom)}, 15, 1);
      rem = remainder;
      start(1);
      sendBits({msg, rem}, 15, 1);
      chk("R9", {3'b0, frameError}, 4'b0000);
    end
    curReq = "R3";
    for (int k = 0; k < 20; k++) begin
      start(1'($urandom));
      sendBits(15'($urandom), 15, 1);
      repeat (2) @(negedge clk);
    end

    running = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  always @(posedge clk) cycles++;
endmodule